// File: doc/BRIEF.md
# Phase-Checked Sign-Magnitude Message Link

This block carries soft messages across the lanes of a permutation network in an iterative decoder and checks every lane for timing faults. Each message has a sign and a magnitude. The sending side adds one extra bit: the sign XORed with a phase bit that flips every clock cycle. The receiving side keeps its own phase, delayed by the fixed link latency, and compares the two. A word that is stuck, or that arrives one cycle late, carries the wrong phase and fails the check.

Lanes are grouped by node. When any lane of a node fails, the receiver drives every decoded message of that node to zero for that cycle and raises the node's error flag. The decoder reads a zeroed message as an erasure, so the fault costs a little convergence instead of passing on a wrong sign. Only the sign is protected, because the iterative decoder absorbs magnitude errors.

The routing network is modelled by a chain of pipeline registers. A test input can hold the last register of a lane for one cycle, which gives the effect of a late-arriving word.

Top module: `phaseCheckedLink`

## Requirements
- R1: Lane k's message sits in msgIn bits [6k+5:6k], with bit 6k+5 as the sign and the lower five bits as the magnitude. msgOut uses the same layout. With no fault, the message driven in cycle n appears on msgOut in cycle n+LINK_LAT+1 (n+3 by default).
- R2: linkWord lane k sits in bits [7k+6:7k]: bit 6 is the sign, bits 5:1 the magnitude, and bit 0 the check bit. The check bit equals the sign XOR the phase in the cycle the message was sent. The phase equals the number of cycles since reset release, modulo 2. A word sent in cycle n appears on linkWord in cycle n+LINK_LAT.
- R3: The phase toggles every cycle. The same message sent in back-to-back cycles therefore appears on linkWord with alternating check bits.
- R4: With no lane frozen, nodeErr stays 0 for every data pattern, including all signs set, all signs clear, negative zero and full-scale magnitude.
- R5: If freezeLane[k] is high in cycle f (f >= LINK_LAT), lane k's received word is held for one more cycle. The stale word shows on linkWord in cycle f+1, and nodeErr[k/6] goes high in cycle f+2.
- R6: In a cycle where nodeErr[j] is high, all six msgOut lanes of node j are zero. The lanes of the other node still carry their normal messages.
- R7: After a single-cycle freeze, nodeErr falls in the next cycle and msgOut resumes with the message that follows the dropped one.
- R8: While rstN is low, linkWord, msgOut and nodeErr are all zero. After release, no error is flagged while the link still holds reset contents.
- R9: Faults on lanes of different nodes in the same cycle set both node flags in the same cycle, each for its own node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgIn | input | NODES*LANES_PER_NODE*6 | Messages to send, one 6-bit sign-magnitude field per lane |
| freezeLane | input | NODES*LANES_PER_NODE | Test control: hold the lane's received word for this cycle |
| linkWord | output | NODES*LANES_PER_NODE*7 | Encoded words as they reach the receiver |
| msgOut | output | NODES*LANES_PER_NODE*6 | Checked messages, zeroed per node on error |
| nodeErr | output | NODES | Per-node check failure flag |

## Verification
The table sends several kinds of message: uniform messages (all zero, all negative at full scale, negative zero), the same message in consecutive cycles, and spread patterns where every lane differs. The uniform and repeated messages separate a check bit that really depends on the phase from one that merely copies the sign. The spread patterns catch lanes that are swapped or misplaced in the packing. Single-lane freezes on each node and on both nodes together show that zero forcing stays within the faulty node's boundary. A freeze at the earliest allowed cycle after a mid-run reset shows that the two phase generators are aligned and that the warm-up suppression ends exactly on time.

// File: rtl/linkPkg.sv
package linkPkg;
  localparam int MAG_W  = 5;
  localparam int MSG_W  = MAG_W + 1;
  localparam int WORD_W = MSG_W + 1;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
  } msg_t;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             chk;
  } word_t;

  typedef struct packed {
    logic txPhase;
    logic rxPhase;
    logic checkEn;
  } linkStrobe_t;
endpackage

// File: rtl/linkCtrl.sv
module linkCtrl
  import linkPkg::*;
#(
  parameter int LINK_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  output linkStrobe_t strobe
);
  localparam int CNT_W = $clog2(LINK_LAT + 1) + 1;
  localparam logic [CNT_W-1:0] WARM_DONE = CNT_W'(LINK_LAT);
  localparam logic RX_INIT = LINK_LAT % 2 == 1;

  logic             txPhase;
  logic             rxPhase;
  logic [CNT_W-1:0] warmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhase <= 1'b0;
      rxPhase <= RX_INIT;
      warmCnt <= '0;
    end else begin
      txPhase <= ~txPhase;
      rxPhase <= ~rxPhase;
      if (warmCnt != WARM_DONE) warmCnt <= warmCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.txPhase = txPhase;
    strobe.rxPhase = rxPhase;
    strobe.checkEn = (warmCnt == WARM_DONE);
  end
endmodule

// File: rtl/laneLink.sv
module laneLink
  import linkPkg::*;
#(
  parameter int LINK_LAT = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  msg_t  msgIn,
  input  logic  txPhase,
  input  logic  freeze,
  output word_t wordOut
);
  word_t encWord;
  word_t stage [LINK_LAT];

  always_comb begin
    encWord.sign = msgIn.sign;
    encWord.mag  = msgIn.mag;
    encWord.chk  = msgIn.sign ^ txPhase;
  end

  for (genvar s = 0; s < LINK_LAT; s++) begin : g_stage
    word_t nextWord;
    logic  holdHere;
    if (s == 0) begin : g_first
      assign nextWord = encWord;
    end else begin : g_rest
      assign nextWord = stage[s-1];
    end
    assign holdHere = freeze && (s == LINK_LAT - 1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else if (!holdHere) stage[s] <= nextWord;
    end
  end

  assign wordOut = stage[LINK_LAT-1];
endmodule

// File: rtl/linkDatapath.sv
module linkDatapath
  import linkPkg::*;
#(
  parameter int NODES          = 2,
  parameter int LANES_PER_NODE = 6,
  parameter int LINK_LAT       = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NODES*LANES_PER_NODE*MSG_W-1:0]  msgIn,
  input  logic [NODES*LANES_PER_NODE-1:0]        freezeLane,
  input  linkStrobe_t                            strobe,
  output logic [NODES*LANES_PER_NODE*WORD_W-1:0] linkWord,
  output logic [NODES*LANES_PER_NODE*MSG_W-1:0]  msgOut,
  output logic [NODES-1:0]                       nodeErr
);
  localparam int LANES = NODES * LANES_PER_NODE;

  word_t             rxWord   [LANES];
  logic [LANES-1:0]  laneBad;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    laneLink #(.LINK_LAT(LINK_LAT)) uLane (
      .clk     (clk),
      .rstN    (rstN),
      .msgIn   (msg_t'(msgIn[k*MSG_W +: MSG_W])),
      .txPhase (strobe.txPhase),
      .freeze  (freezeLane[k]),
      .wordOut (rxWord[k])
    );
    assign linkWord[k*WORD_W +: WORD_W] = rxWord[k];
    assign laneBad[k] = strobe.checkEn &
                        (rxWord[k].sign ^ rxWord[k].chk ^ strobe.rxPhase);
  end

  for (genvar j = 0; j < NODES; j++) begin : g_node
    localparam int BASE = j * LANES_PER_NODE;
    logic groupBad;
    assign groupBad = |laneBad[BASE +: LANES_PER_NODE];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nodeErr[j] <= 1'b0;
        msgOut[BASE*MSG_W +: LANES_PER_NODE*MSG_W] <= '0;
      end else begin
        nodeErr[j] <= groupBad;
        for (int m = 0; m < LANES_PER_NODE; m++) begin
          msgOut[(BASE+m)*MSG_W +: MSG_W] <= groupBad ? '0 :
            {rxWord[BASE+m].sign, rxWord[BASE+m].mag};
        end
      end
    end
  end
endmodule

// File: rtl/phaseCheckedLink.sv
module phaseCheckedLink
  import linkPkg::*;
#(
  parameter int NODES          = 2,
  parameter int LANES_PER_NODE = 6,
  parameter int LINK_LAT       = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NODES*LANES_PER_NODE*MSG_W-1:0]  msgIn,
  input  logic [NODES*LANES_PER_NODE-1:0]        freezeLane,
  output logic [NODES*LANES_PER_NODE*WORD_W-1:0] linkWord,
  output logic [NODES*LANES_PER_NODE*MSG_W-1:0]  msgOut,
  output logic [NODES-1:0]                       nodeErr
);
  linkStrobe_t strobe;

  linkCtrl #(.LINK_LAT(LINK_LAT)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  linkDatapath #(
    .NODES          (NODES),
    .LANES_PER_NODE (LANES_PER_NODE),
    .LINK_LAT       (LINK_LAT)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .msgIn      (msgIn),
    .freezeLane (freezeLane),
    .strobe     (strobe),
    .linkWord   (linkWord),
    .msgOut     (msgOut),
    .nodeErr    (nodeErr)
  );
endmodule

// File: rtl/phaseCheckedLinkChk.sv
module phaseCheckedLinkChk
  import linkPkg::*;
#(
  parameter int NODES          = 2,
  parameter int LANES_PER_NODE = 6,
  parameter int LINK_LAT       = 2
) (
  input logic                                   clk,
  input logic                                   rstN,
  input logic [NODES*LANES_PER_NODE-1:0]        freezeLane,
  input logic [NODES*LANES_PER_NODE*WORD_W-1:0] linkWord,
  input logic [NODES*LANES_PER_NODE*MSG_W-1:0]  msgOut,
  input logic [NODES-1:0]                       nodeErr
);
  localparam int LANES = NODES * LANES_PER_NODE;
  localparam int CNT_W = $clog2(LINK_LAT + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LINK_LAT + 1);

  logic [CNT_W-1:0] sinceRst;
  logic [LANES-1:0] frzD1, frzD2, tagD1;
  logic [LANES-1:0] tagNow;

  for (genvar k = 0; k < LANES; k++) begin : g_tag
    assign tagNow[k] = linkWord[k*WORD_W + WORD_W - 1] ^ linkWord[k*WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      frzD1    <= '0;
      frzD2    <= '0;
      tagD1    <= '0;
    end else begin
      if (sinceRst != CNT_MAX) sinceRst <= sinceRst + 1'b1;
      frzD1 <= freezeLane;
      frzD2 <= frzD1;
      tagD1 <= tagNow;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_laneChk
    localparam int NODE = k / LANES_PER_NODE;

    a_r5_freeze_flags: assert property (@(posedge clk) disable iff (!rstN)
      (freezeLane[k] && sinceRst >= CNT_W'(LINK_LAT) && !frzD1[k])
        |=> ##1 nodeErr[NODE]);

    a_r3_phase_alternates: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst == CNT_MAX && !frzD1[k] && !frzD2[k])
        |-> tagNow[k] != tagD1[k]);
  end

  for (genvar j = 0; j < NODES; j++) begin : g_nodeChk
    localparam int BASE = j * LANES_PER_NODE;

    a_r6_zero_forced: assert property (@(posedge clk) disable iff (!rstN)
      nodeErr[j] |-> msgOut[BASE*MSG_W +: LANES_PER_NODE*MSG_W] == '0);

    a_r4_err_has_cause: assert property (@(posedge clk) disable iff (!rstN)
      nodeErr[j] |-> |frzD2[BASE +: LANES_PER_NODE]);

    a_r7_err_clears: assert property (@(posedge clk) disable iff (!rstN)
      (nodeErr[j] && !(|frzD1[BASE +: LANES_PER_NODE])) |=> !nodeErr[j]);
  end
endmodule

bind phaseCheckedLink phaseCheckedLinkChk #(
  .NODES          (NODES),
  .LANES_PER_NODE (LANES_PER_NODE),
  .LINK_LAT       (LINK_LAT)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .freezeLane (freezeLane),
  .linkWord   (linkWord),
  .msgOut     (msgOut),
  .nodeErr    (nodeErr)
);

// File: tb/phaseCheckedLink_test.sv
`timescale 1ns/1ps
module phaseCheckedLink_test;
  localparam int NODES = 2;
  localparam int D     = 6;
  localparam int LAT   = 2;
  localparam int LANES = NODES * D;
  localparam int NV    = 20;

  // entry: {seed[5:0], spread[5:0], freeze[11:0]}
  localparam logic [23:0] VEC [NV] = '{
    24'h000000, 24'hFC0000, 24'hFC0000, 24'h800000, 24'h7C1000,
    24'h547001, 24'hA8B000, 24'h043000, 24'hCC5000, 24'h309800,
    24'hF82000, 24'h411000, 24'h9CD000, 24'h146108, 24'hE01000,
    24'h68F000, 24'hBC0000, 24'h03F000, 24'h444040, 24'hF0A000
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                  rstN;
  logic [LANES*6-1:0]    msgIn;
  logic [LANES-1:0]      freezeLane;
  logic [LANES*7-1:0]    linkWord;
  logic [LANES*6-1:0]    msgOut;
  logic [NODES-1:0]      nodeErr;

  phaseCheckedLink #(.NODES(NODES), .LANES_PER_NODE(D), .LINK_LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .msgIn(msgIn), .freezeLane(freezeLane),
    .linkWord(linkWord), .msgOut(msgOut), .nodeErr(nodeErr)
  );

  int checks = 0;
  int fails  = 0;
  int cyc;
  logic [LANES*6-1:0] hMsg [256];
  logic [LANES-1:0]   hFrz [256];

  function automatic logic [LANES*6-1:0] mkMsg(logic [5:0] seed, logic [5:0] spread);
    logic [LANES*6-1:0] m;
    for (int k = 0; k < LANES; k++) m[k*6 +: 6] = seed ^ 6'(k * spread);
    return m;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // expected outputs for cycle n, from the requirements (R1, R2, R5, R6, R9)
  task automatic checkCycle(int n);
    logic [LANES*7-1:0] expWord;
    logic [LANES*6-1:0] expOut;
    logic [NODES-1:0]   expErr;
    for (int k = 0; k < LANES; k++) begin
      int src;
      logic [5:0] m;
      src = n - LAT;
      if (n - 1 >= 0 && hFrz[n-1][k]) src = n - LAT - 1;
      if (src < 0) expWord[k*7 +: 7] = '0;
      else begin
        m = hMsg[src][k*6 +: 6];
        expWord[k*7 +: 7] = {m, m[5] ^ src[0]};
      end
    end
    for (int j = 0; j < NODES; j++) begin
      expErr[j] = (n - 2 >= 0) && (|hFrz[n-2][j*D +: D]);
      for (int m = 0; m < D; m++) begin
        int k;
        k = j * D + m;
        if (expErr[j] || n - LAT - 1 < 0) expOut[k*6 +: 6] = '0;
        else expOut[k*6 +: 6] = hMsg[n-LAT-1][k*6 +: 6];
      end
    end
    check("R2/R3 linkWord", 128'(linkWord), 128'(expWord));
    check("R1/R6/R7 msgOut", 128'(msgOut), 128'(expOut));
    check("R4/R5/R9 nodeErr", 128'(nodeErr), 128'(expErr));
  endtask

  task automatic stepDrive(logic [5:0] seed, logic [5:0] spread, logic [LANES-1:0] frz);
    checkCycle(cyc);
    hMsg[cyc] = mkMsg(seed, spread);
    hFrz[cyc] = frz;
    msgIn      = hMsg[cyc];
    freezeLane = frz;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    msgIn = '0;
    freezeLane = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs quiet during reset
    check("R8 reset linkWord", 128'(linkWord), 128'(0));
    check("R8 reset msgOut", 128'(msgOut), 128'(0));
    check("R8 reset nodeErr", 128'(nodeErr), 128'(0));
    rstN = 1'b1;
    cyc = 0;

    for (int i = 0; i < NV; i++)
      stepDrive(VEC[i][23:18], VEC[i][17:12], VEC[i][11:0]);
    for (int i = 0; i < 4; i++) stepDrive(6'h00, 6'h00, '0);

    // mid-run reset with traffic in flight (R8)
    for (int i = 0; i < 3; i++) stepDrive(6'h2B, 6'h07, '0);
    rstN = 1'b0;
    #1;
    check("R8 midrun linkWord", 128'(linkWord), 128'(0));
    check("R8 midrun msgOut", 128'(msgOut), 128'(0));
    check("R8 midrun nodeErr", 128'(nodeErr), 128'(0));
    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    // R5 boundary: freeze at earliest allowed cycle, lane 0 and lane 7 (R9)
    for (int i = 0; i < 10; i++)
      stepDrive(6'(i * 11), 6'h05, (i == LAT) ? 12'h081 : 12'h000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule